// File: doc/BRIEF.md
# Three-Lane Serial Register-Read Master

This engine reads a single register from a remote RF device over a five-wire link. The link has one link clock, one frame-select strobe and three data lanes that reverse direction. A host places a 14-bit register address on `addr` and pulses `start`. The engine then drives a complete read frame on its own.

The command word is the read code combined with the shifted address. It goes out three bits per link clock, lowest bit first. The engine then releases the lanes and runs two idle turnaround clocks. After that it gathers a 16-bit response, again three bits per clock. The last response beat contributes a single bit.

The link clock comes from the system clock. Every half-period of the link clock lasts `HALF_CYC` system cycles. The result returns on `rdata` together with a one-cycle `done` pulse.

Top module: `lane3_reg_reader`

## Requirements
- R1: While idle, `lnk_clk`, `lnk_sel` and every bit of `lane_oe` are low and `busy` is low. Once a request is accepted, `lnk_sel` rises while `lnk_clk` is still low. It then stays high until the frame ends.
- R2: The command word is `(RD_CODE | (addr << ADDR_OFS))`, keeping only bits 13:0. It is followed by a fifteenth lane slot that is always 0.
- R3: The command phase has 5 beats. In beat b (0..4), lane j (0..2) carries word bit 3*b+j. The lanes are set while `lnk_clk` is low, `lane_oe` is 3'b111 during the phase, and lanes hold steady while `lnk_clk` is high.
- R4: After the fifth command beat, `lnk_clk` returns low. `lane_oe` drops to 3'b000 in that same system cycle.
- R5: Two clock pulses (high, then low) with no capture follow. Then six response pulses run. At the end of the low half of response pulse k (0..5), `lane_in[j]` is stored into result bit 3*k+j.
- R6: On response pulse k=5 only `lane_in[0]` is kept, and it becomes result bit 15. `lane_in[1]` and `lane_in[2]` have no effect on that beat.
- R7: Every high and every low half of `lnk_clk` inside a frame, and the opening select-only step, lasts exactly `HALF_CYC` system cycles.
- R8: When the last response pulse ends, `lnk_sel` falls, `busy` falls and `done` is high for exactly one cycle, all in the same cycle. `rdata` shows the result from that cycle and holds it until the next `done`.
- R9: A `start` that arrives while `busy` is high is ignored. The frame in progress keeps its timing, its command word and its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted only while idle |
| addr | input | 14 | Register address for the request |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| rdata | output | 16 | Last read result |
| lnk_clk | output | 1 | Link clock |
| lnk_sel | output | 1 | Frame-select strobe |
| lane_oe | output | 3 | Output enable per data lane |
| lane_out | output | 3 | Data driven on the lanes |
| lane_in | input | 3 | Data received from the lanes |

## Verification
Suppose the phase, the beat counter or the half-period timer goes wrong. The link pins then leave the expected per-cycle timeline in the very next system cycle, because every pin is compared on every clock. A command word that is shifted or packed wrongly shows up as a mismatch on `lane_out` during the beat that carries it. An error in the response capture stays hidden until `done`. At that point `rdata` is compared with the pattern the device model sent, including junk driven on the two upper lanes in the final beat.

// File: rtl/lrr_pkg.sv
package lrr_pkg;
    localparam int LANES       = 3;
    localparam int CMD_BITS    = 14;
    localparam int RSP_BITS    = 16;
    localparam int CMD_BEATS   = (CMD_BITS + LANES - 1) / LANES;
    localparam int RSP_BEATS   = (RSP_BITS + LANES - 1) / LANES;
    localparam int TURN_BEATS  = 2;
    localparam int SLOT_W      = CMD_BEATS * LANES;
    localparam int ACC_W       = RSP_BEATS * LANES;
    localparam int BEAT_W      = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CLO,
        ST_CHI,
        ST_TURN,
        ST_DHI,
        ST_DLO,
        ST_RHI,
        ST_RLO
    } lrr_state_e;

    typedef struct packed {
        lrr_state_e              state;
        logic [BEAT_W-1:0]       beat;
        logic [SLOT_W-1:0]       shreg;
        logic [ACC_W-1:0]        acc;
        logic [RSP_BITS-1:0]     rdata;
        logic                    done;
        logic                    sel;
        logic                    lclk;
        logic [LANES-1:0]        oe;
        logic [LANES-1:0]        dout;
    } lrr_regs_t;
endpackage

// File: rtl/lrr_half_timer.sv
module lrr_half_timer #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    generate
        if (HALF_CYC <= 1) begin : g_every
            assign tick = run;
        end else begin : g_count
            localparam int CW = $clog2(HALF_CYC);
            localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                if (!run || cnt_q == LAST) cnt_d = '0;
                else                       cnt_d = cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick = run && (cnt_q == LAST);

            p_count_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !run |=> cnt_q == '0);
        end
    endgenerate
endmodule

// File: rtl/lrr_cmd_word.sv
module lrr_cmd_word #(
    parameter logic [13:0] RD_CODE  = 14'h0001,
    parameter int          ADDR_OFS = 1
) (
    input  logic [13:0] addr,
    output logic [13:0] word
);
    logic [31:0] wide;
    always_comb begin
        wide = 32'(RD_CODE) | (32'(addr) << ADDR_OFS);
        word = wide[13:0];
    end
endmodule

// File: rtl/lane3_reg_reader.sv
module lane3_reg_reader
    import lrr_pkg::*;
#(
    parameter int          HALF_CYC = 2,
    parameter logic [13:0] RD_CODE  = 14'h0001,
    parameter int          ADDR_OFS = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [13:0]         addr,
    output logic                busy,
    output logic                done,
    output logic [15:0]         rdata,
    output logic                lnk_clk,
    output logic                lnk_sel,
    output logic [2:0]          lane_oe,
    output logic [2:0]          lane_out,
    input  logic [2:0]          lane_in
);
    lrr_regs_t r_q, r_d;
    logic      tick;
    logic [CMD_BITS-1:0] cmd_word;

    lrr_half_timer #(.HALF_CYC(HALF_CYC)) i_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (r_q.state != ST_IDLE),
        .tick (tick)
    );

    lrr_cmd_word #(.RD_CODE(RD_CODE), .ADDR_OFS(ADDR_OFS)) i_word (
        .addr(addr),
        .word(cmd_word)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (r_q.state == ST_IDLE) begin
            if (start) begin
                r_d.state = ST_SETUP;
                r_d.shreg = {{(SLOT_W-CMD_BITS){1'b0}}, cmd_word};
                r_d.acc   = '0;
                r_d.beat  = '0;
                r_d.sel   = 1'b1;
                r_d.lclk  = 1'b0;
                r_d.oe    = '1;
                r_d.dout  = '0;
            end
        end else if (tick) begin
            case (r_q.state)
                ST_SETUP: begin
                    r_d.state = ST_CLO;
                    r_d.dout  = r_q.shreg[LANES-1:0];
                end
                ST_CLO: begin
                    r_d.state = ST_CHI;
                    r_d.lclk  = 1'b1;
                end
                ST_CHI: begin
                    r_d.lclk  = 1'b0;
                    r_d.shreg = r_q.shreg >> LANES;
                    if (r_q.beat == BEAT_W'(CMD_BEATS - 1)) begin
                        r_d.state = ST_TURN;
                        r_d.oe    = '0;
                        r_d.dout  = '0;
                        r_d.beat  = '0;
                    end else begin
                        r_d.state = ST_CLO;
                        r_d.beat  = r_q.beat + 1'b1;
                        r_d.dout  = r_q.shreg[2*LANES-1:LANES];
                    end
                end
                ST_TURN: begin
                    r_d.state = ST_DHI;
                    r_d.lclk  = 1'b1;
                end
                ST_DHI: begin
                    r_d.state = ST_DLO;
                    r_d.lclk  = 1'b0;
                end
                ST_DLO: begin
                    r_d.lclk = 1'b1;
                    if (r_q.beat == BEAT_W'(TURN_BEATS - 1)) begin
                        r_d.state = ST_RHI;
                        r_d.beat  = '0;
                    end else begin
                        r_d.state = ST_DHI;
                        r_d.beat  = r_q.beat + 1'b1;
                    end
                end
                ST_RHI: begin
                    r_d.state = ST_RLO;
                    r_d.lclk  = 1'b0;
                end
                ST_RLO: begin
                    r_d.acc[int'(r_q.beat)*LANES +: LANES] = lane_in;
                    if (r_q.beat == BEAT_W'(RSP_BEATS - 1)) begin
                        r_d.state = ST_IDLE;
                        r_d.sel   = 1'b0;
                        r_d.done  = 1'b1;
                        r_d.rdata = r_d.acc[RSP_BITS-1:0];
                        r_d.beat  = '0;
                    end else begin
                        r_d.state = ST_RHI;
                        r_d.beat  = r_q.beat + 1'b1;
                        r_d.lclk  = 1'b1;
                    end
                end
                default: r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.state != ST_IDLE);
    assign done     = r_q.done;
    assign rdata    = r_q.rdata;
    assign lnk_clk  = r_q.lclk;
    assign lnk_sel  = r_q.sel;
    assign lane_oe  = r_q.oe;
    assign lane_out = r_q.dout;

    // Run-length tracker for the link clock, used only by the half-period check.
    localparam int RW = $clog2(HALF_CYC + 2) + 1;
    logic          lclk_prev_q;
    logic [RW-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lclk_prev_q <= 1'b0;
            run_q       <= '0;
        end else begin
            lclk_prev_q <= lnk_clk;
            if (lnk_clk != lclk_prev_q)  run_q <= RW'(1);
            else if (run_q != '1)        run_q <= run_q + 1'b1;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!lnk_clk && !lnk_sel && lane_oe == 3'b000));
    p_sel_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> lnk_sel);
    p_lane_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_clk |-> ($stable(lane_out) && $stable(lane_oe)));
    p_oe_drop_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lane_oe[0]) |-> (!lnk_clk && lnk_sel));
    p_half_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_clk != lclk_prev_q) |-> (32'(run_q) >= HALF_CYC));
    p_done_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !lnk_sel && $past(busy)));
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rdata));
endmodule

// File: tb/test_lane3_reg_reader.sv
`timescale 1ns/1ps
module test_lane3_reg_reader;
    localparam int          H    = 3;
    localparam logic [13:0] CODE = 14'h0001;
    localparam int          OFS  = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [13:0] addr = '0;
    logic        busy, done, lnk_clk, lnk_sel;
    logic [15:0] rdata;
    logic [2:0]  lane_oe, lane_out;
    logic [2:0]  lane_in = 3'b101;

    always #2 clk = ~clk;

    lane3_reg_reader #(.HALF_CYC(H), .RD_CODE(CODE), .ADDR_OFS(OFS)) i_lane3_reg_reader (
        .clk(clk), .rst_n(rst_n), .start(start), .addr(addr),
        .busy(busy), .done(done), .rdata(rdata),
        .lnk_clk(lnk_clk), .lnk_sel(lnk_sel),
        .lane_oe(lane_oe), .lane_out(lane_out), .lane_in(lane_in)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    // Remote device model: reacts to link clock rising edges while selected.
    int          edge_n = 0;
    logic        dev_prev = 1'b0;
    logic [14:0] dev_cmd = '0;
    logic [15:0] dev_resp = '0;
    logic [1:0]  dev_junk = '0;
    always @(negedge clk) begin
        if (!lnk_sel) begin
            edge_n = 0;
        end else if (lnk_clk && !dev_prev) begin
            edge_n++;
            if (edge_n <= 5) begin
                dev_cmd[3*(edge_n-1) +: 3] = lane_out;
                chk(lane_oe == 3'b111, "R3", "lanes driven at command edge", 32'(lane_oe), 32'h7);
            end else if (edge_n >= 8 && edge_n <= 13) begin
                if (edge_n == 13) lane_in = {dev_junk, dev_resp[15]};
                else              lane_in = dev_resp[3*(edge_n-8) +: 3];
            end
        end
        dev_prev = lnk_clk;
    end

    function automatic logic [13:0] exp_word(input logic [13:0] a);
        logic [31:0] t;
        t = 32'(CODE) | (32'(a) << OFS);
        return t[13:0];
    endfunction

    // Expected pins per system cycle: {sel, clk, oe[2:0], dout[2:0]}
    task automatic push_step(ref logic [7:0] q[$], input logic s, input logic c,
                             input logic [2:0] oe, input logic [2:0] d);
        for (int i = 0; i < H; i++) q.push_back({s, c, oe, d});
    endtask

    task automatic run_txn(input logic [13:0] a, input logic [15:0] resp,
                           input logic [1:0] junk, input bit poke);
        logic [7:0]  q[$];
        logic [14:0] w;
        logic [7:0]  got;
        w = {1'b0, exp_word(a)};
        dev_resp = resp;
        dev_junk = junk;
        push_step(q, 1, 0, 3'b111, 3'b000);
        for (int b = 0; b < 5; b++) begin
            push_step(q, 1, 0, 3'b111, w[3*b +: 3]);
            push_step(q, 1, 1, 3'b111, w[3*b +: 3]);
        end
        push_step(q, 1, 0, 3'b000, 3'b000);
        for (int b = 0; b < 8; b++) begin
            push_step(q, 1, 1, 3'b000, 3'b000);
            push_step(q, 1, 0, 3'b000, 3'b000);
        end
        start = 1'b1;
        addr  = a;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < q.size(); i++) begin
            got = {lnk_sel, lnk_clk, lane_oe, lane_out};
            chk(got == q[i], "R1 R3 R4 R5 R7", $sformatf("pin timeline cycle %0d", i),
                32'(got), 32'(q[i]));
            chk(busy && !done, "R8", "busy high, done low mid-frame", {30'd0, busy, done}, 32'h2);
            if (poke && i == 40) begin
                start = 1'b1;
                addr  = a ^ 14'h2AAA;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        chk(done && !busy && !lnk_sel, "R8", "done with busy and sel low",
            {29'd0, done, busy, lnk_sel}, 32'h4);
        chk(rdata == resp, "R5 R6", "read result", 32'(rdata), 32'(resp));
        chk(dev_cmd == w, "R2", "command word seen by device", 32'(dev_cmd), 32'(w));
        if (poke) chk(dev_cmd == w && rdata == resp, "R9", "start while busy ignored",
                      32'(dev_cmd), 32'(w));
        @(negedge clk);
        chk(!done && !busy, "R8", "done lasts one cycle", {30'd0, done, busy}, 32'h0);
        chk(rdata == resp, "R8", "rdata held after done", 32'(rdata), 32'(resp));
        chk(!lnk_clk && !lnk_sel && lane_oe == 3'b000, "R1", "idle pins after frame",
            {29'd0, lnk_clk, lnk_sel, lane_oe == 3'b000}, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "WDOG", "watchdog expired", 32'd0, 32'd1);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !lnk_clk && !lnk_sel && lane_oe == 3'b000 && rdata == 16'h0,
            "R1", "reset state", {28'd0, busy, done, lnk_clk, lnk_sel}, 32'h0);
        run_txn(14'h0000, 16'hA5C3, 2'b11, 0);
        run_txn(14'h3FFF, 16'hFFFF, 2'b00, 0);
        run_txn(14'h1555, 16'h8000, 2'b11, 1);   // R9 poke mid-frame
        run_txn(14'h2ABC, 16'h7FFF, 2'b11, 0);   // R6 junk must not reach bit 15
        repeat (2) @(negedge clk);
        chk(!done && rdata == 16'h7FFF, "R8", "rdata stable while idle", 32'(rdata), 32'h7FFF);
        run_txn(14'h2001, 16'h1234, 2'b01, 1);
        report();
    end
endmodule